// File: doc/BRIEF.md
# In-Order Retirement Instruction Table

This block is a circular table that follows every in-flight two-operation instruction from the cycle it is merged into the machine until it retires. An allocation stores the result tags of the instruction's two operations and, optionally, the index of a write-buffer slot the instruction owns. Each entry then watches the result-distribution buses. When a valid result carries a tag stored in the entry, that operation is marked complete and any exception flags on that bus are kept with the entry.

Only the oldest entry can leave the table. When both of its operations are complete it either commits or traps. A commit releases its write-buffer slot to memory, if it owns one. A trap happens when flags were captured. For conditional branches, operation 0 is the branch itself and is completed by the branch-confirm input. A mispredict on a branch drops every younger instruction in one cycle.

Top module: `retire_table`

## Requirements
- R1: After reset the table is empty: `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `retire_o`, `rel_valid_o` and `trap_o` are 0.
- R2: An accepted allocation writes the entry at `alloc_idx_o`, which then advances by one modulo 8. While 8 entries are held, `alloc_ready_o` is 0 and a request is ignored.
- R3: A valid distribution bus whose tag equals a stored, not yet complete operation tag of a live entry marks that operation complete at the next edge. It also ORs that bus's exception flags into the entry's flags. Tags of an entry allocated in the same cycle are not matched.
- R4: Only the oldest entry, and only once both of its operations are complete, can commit (`retire_o`) or trap. At most one entry leaves per cycle, and younger complete entries wait for it.
- R5: A flag-free oldest complete entry that owns a write-buffer slot drives `rel_valid_o` = 1 and that slot on `rel_wb_id_o`. It commits only in a cycle where `rel_ready_i` is 1.
- R6: An oldest complete entry with any flag set drives `trap_o` = 1 and its flags on `trap_exc_o`, with `retire_o` and `rel_valid_o` at 0. At that edge the whole table is emptied, and the next allocation uses index 0.
- R7: `br_ok_i` with `br_idx_i` marks operation 0 of that entry complete, and this shows from the following cycle.
- R8: `br_miss_i` with `br_idx_i` marks operation 0 of that entry complete and drops every younger entry at the same edge, so the next allocation index becomes `br_idx_i`+1. An allocation request in that cycle is ignored.
- R9: A flag-free oldest complete entry without a write-buffer slot commits regardless of `rel_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_tag0_i | input | 6 | Result tag of operation 0 (branch operation for branches) |
| alloc_tag1_i | input | 6 | Result tag of operation 1 |
| alloc_has_wb_i | input | 1 | Instruction owns a write-buffer slot |
| alloc_wb_id_i | input | 3 | Owned write-buffer slot index |
| alloc_ready_o | output | 1 | Table not full |
| alloc_idx_o | output | 3 | Index the next allocation takes |
| dist_valid_i | input | 2 | Valid bit per distribution bus |
| dist_tag_i | input | 12 | Tag per bus, bus b at bits 6b+5..6b |
| dist_exc_i | input | 4 | Exception flags per bus, bus b at bits 2b+1..2b |
| br_ok_i | input | 1 | Branch prediction confirmed correct |
| br_miss_i | input | 1 | Branch prediction found wrong |
| br_idx_i | input | 3 | Table index of the confirmed branch |
| rel_ready_i | input | 1 | Memory accepts a write-buffer release |
| rel_valid_o | output | 1 | Write-buffer release offered |
| rel_wb_id_o | output | 3 | Slot being released |
| retire_o | output | 1 | Oldest entry commits at this edge |
| trap_o | output | 1 | Oldest entry traps at this edge |
| trap_exc_o | output | 2 | Flags of the trapping entry |

## Verification
The hardest case to reach is a mispredict arriving while the table is full with its pointers wrapped, possibly in the same cycle as a commit, because the surviving count then depends on both the head advance and the branch position. The stimulus repeatedly stops all distribution and keeps allocating until the table is full and stalled. It then issues a mispredict on a live branch deep in the window and reopens the buses, while a queue-based model predicts every output in every cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;
  parameter int TAG_W = 6;
  parameter int EXC_W = 2;
  parameter int WB_W  = 3;
  parameter int N_BUS = 2;
  parameter int N_OPS = 2;

  typedef struct packed {
    logic [TAG_W-1:0] tag1;
    logic [TAG_W-1:0] tag0;
    logic             has_wb;
    logic [WB_W-1:0]  wb_id;
  } alloc_t;
endpackage

// File: rtl/rt_entry.sv
module rt_entry import rt_pkg::*; (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_en_i,
  input  alloc_t                       alloc_i,
  input  logic                         clr_i,
  input  logic                         br_set_i,
  input  logic [N_BUS-1:0]             dist_valid_i,
  input  logic [N_BUS-1:0][TAG_W-1:0]  dist_tag_i,
  input  logic [N_BUS-1:0][EXC_W-1:0]  dist_exc_i,
  output logic                         done_o,
  output logic [EXC_W-1:0]             exc_o,
  output logic                         has_wb_o,
  output logic [WB_W-1:0]              wb_id_o
);
  logic                        valid_q;
  logic [N_OPS-1:0]            rdy_q;
  logic [N_OPS-1:0][TAG_W-1:0] tag_q;
  logic [EXC_W-1:0]            exc_q;
  logic                        has_wb_q;
  logic [WB_W-1:0]             wb_q;

  logic [N_OPS-1:0] hit;
  logic [EXC_W-1:0] exc_in;

  always_comb begin
    exc_in = '0;
    for (int o = 0; o < N_OPS; o++) begin
      hit[o] = 1'b0;
      for (int b = 0; b < N_BUS; b++) begin
        if (valid_q && !rdy_q[o] && dist_valid_i[b] && dist_tag_i[b] == tag_q[o]) begin
          hit[o] = 1'b1;
          exc_in = exc_in | dist_exc_i[b];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      rdy_q    <= '0;
      tag_q    <= '0;
      exc_q    <= '0;
      has_wb_q <= 1'b0;
      wb_q     <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
      exc_q   <= '0;
    end else if (alloc_en_i) begin
      valid_q  <= 1'b1;
      rdy_q    <= '0;
      exc_q    <= '0;
      tag_q    <= {alloc_i.tag1, alloc_i.tag0};
      has_wb_q <= alloc_i.has_wb;
      wb_q     <= alloc_i.wb_id;
    end else if (valid_q) begin
      rdy_q    <= rdy_q | hit | {{(N_OPS-1){1'b0}}, br_set_i};
      exc_q    <= exc_q | exc_in;
    end
  end

  assign done_o   = valid_q & (&rdy_q);
  assign exc_o    = exc_q;
  assign has_wb_o = has_wb_q;
  assign wb_id_o  = wb_q;

  assert_br_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_set_i && valid_q && !clr_i |=> rdy_q[0]);

  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && rdy_q[1] && !clr_i && !alloc_en_i |=> rdy_q[1] && valid_q);
endmodule

// File: rtl/rt_ptr_ctrl.sv
module rt_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          retire_i,
  input  logic          flush_all_i,
  input  logic          miss_i,
  input  logic [IW-1:0] miss_idx_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic [CW-1:0] count_o
);
  logic [IW-1:0] head_q, tail_q, head_d, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] br_off;

  assign br_off = miss_idx_i - head_q;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush_all_i) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else if (miss_i) begin
      head_d = head_q + IW'(retire_i);
      tail_d = miss_idx_i + IW'(1);
      cnt_d  = CW'(br_off) + CW'(1) - CW'(retire_i);
    end else begin
      head_d = head_q + IW'(retire_i);
      tail_d = tail_q + IW'(alloc_i);
      cnt_d  = cnt_q + CW'(alloc_i) - CW'(retire_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/retire_table.sv
module retire_table import rt_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_valid_i,
  input  logic [TAG_W-1:0]       alloc_tag0_i,
  input  logic [TAG_W-1:0]       alloc_tag1_i,
  input  logic                   alloc_has_wb_i,
  input  logic [WB_W-1:0]        alloc_wb_id_i,
  output logic                   alloc_ready_o,
  output logic [IW-1:0]          alloc_idx_o,
  input  logic [N_BUS-1:0]       dist_valid_i,
  input  logic [N_BUS*TAG_W-1:0] dist_tag_i,
  input  logic [N_BUS*EXC_W-1:0] dist_exc_i,
  input  logic                   br_ok_i,
  input  logic                   br_miss_i,
  input  logic [IW-1:0]          br_idx_i,
  input  logic                   rel_ready_i,
  output logic                   rel_valid_o,
  output logic [WB_W-1:0]        rel_wb_id_o,
  output logic                   retire_o,
  output logic                   trap_o,
  output logic [EXC_W-1:0]       trap_exc_o
);
  logic [IW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          full, alloc_fire, head_done, head_exc;
  logic [CW-1:0] younger;
  alloc_t        req;

  logic [N_BUS-1:0][TAG_W-1:0] dtag;
  logic [N_BUS-1:0][EXC_W-1:0] dexc;
  logic [DEPTH-1:0]            e_done, e_has_wb;
  logic [DEPTH-1:0][EXC_W-1:0] e_exc;
  logic [DEPTH-1:0][WB_W-1:0]  e_wb;

  assign dtag = dist_tag_i;
  assign dexc = dist_exc_i;
  assign req  = '{tag1: alloc_tag1_i, tag0: alloc_tag0_i,
                  has_wb: alloc_has_wb_i, wb_id: alloc_wb_id_i};

  assign head_done   = e_done[head];
  assign head_exc    = |e_exc[head];
  assign trap_o      = head_done & head_exc;
  assign trap_exc_o  = e_exc[head];
  assign rel_valid_o = head_done & ~head_exc & e_has_wb[head];
  assign rel_wb_id_o = e_wb[head];
  assign retire_o    = head_done & ~head_exc & (~e_has_wb[head] | rel_ready_i);

  assign full          = (count == CW'(DEPTH));
  assign alloc_ready_o = ~full;
  assign alloc_idx_o   = tail;
  assign alloc_fire    = alloc_valid_i & ~full & ~trap_o & ~br_miss_i;
  // entries strictly after the branch, up to the current tail
  assign younger       = count - CW'(IW'(br_idx_i - head)) - CW'(1);

  rt_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc_fire),
    .retire_i    (retire_o),
    .flush_all_i (trap_o),
    .miss_i      (br_miss_i),
    .miss_idx_i  (br_idx_i),
    .head_o      (head),
    .tail_o      (tail),
    .count_o     (count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0] off;
    logic          kill, clr, alloc_en, br_set;
    assign off      = IW'(i) - br_idx_i;
    assign kill     = br_miss_i & (off != '0) & (CW'(off) <= younger);
    assign clr      = trap_o | kill | (retire_o & (head == IW'(i)));
    assign alloc_en = alloc_fire & (tail == IW'(i));
    assign br_set   = (br_ok_i | br_miss_i) & (br_idx_i == IW'(i));

    rt_entry u_ent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_en_i   (alloc_en),
      .alloc_i      (req),
      .clr_i        (clr),
      .br_set_i     (br_set),
      .dist_valid_i (dist_valid_i),
      .dist_tag_i   (dtag),
      .dist_exc_i   (dexc),
      .done_o       (e_done[i]),
      .exc_o        (e_exc[i]),
      .has_wb_o     (e_has_wb[i]),
      .wb_id_o      (e_wb[i])
    );
  end

  assert_full_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_ready_o && !retire_o && !trap_o && !br_miss_i |=> !alloc_ready_o);

  assert_one_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retire_o, trap_o}));

  assert_rel_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_o && !rel_ready_i |-> !retire_o);

  assert_trap_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> alloc_idx_o == '0 && alloc_ready_o && !retire_o && !trap_o);

  assert_miss_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_miss_i && !trap_o |=> alloc_idx_o == IW'($past(br_idx_i) + IW'(1)));
endmodule

// File: tb/retire_table_bench.sv
`timescale 1ns/1ps
module retire_table_bench;
  typedef struct {
    int idx; int t0; int t1; bit r0; bit r1; int exc; bit has_wb; int wb; bit br;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [5:0]  alloc_tag0 = '0, alloc_tag1 = '0;
  logic        alloc_has_wb = 1'b0;
  logic [2:0]  alloc_wb_id = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic [1:0]  dist_valid = '0;
  logic [11:0] dist_tag = '0;
  logic [3:0]  dist_exc = '0;
  logic        br_ok = 1'b0, br_miss = 1'b0;
  logic [2:0]  br_idx = '0;
  logic        rel_ready = 1'b0;
  logic        rel_valid, retire, trap;
  logic [2:0]  rel_wb_id;
  logic [1:0]  trap_exc;

  int   checks = 0, errors = 0;
  bit   finished = 1'b0;
  ent_t q[$];
  int   mhead = 0;
  int   tagc = 0;
  bit   is_br_new = 1'b0;

  always #5 clk = ~clk;

  retire_table u_retire_table (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_tag0_i(alloc_tag0), .alloc_tag1_i(alloc_tag1),
    .alloc_has_wb_i(alloc_has_wb), .alloc_wb_id_i(alloc_wb_id),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .dist_valid_i(dist_valid), .dist_tag_i(dist_tag), .dist_exc_i(dist_exc),
    .br_ok_i(br_ok), .br_miss_i(br_miss), .br_idx_i(br_idx),
    .rel_ready_i(rel_ready), .rel_valid_o(rel_valid), .rel_wb_id_o(rel_wb_id),
    .retire_o(retire), .trap_o(trap), .trap_exc_o(trap_exc)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic calc(output bit ar, output int ai, output bit ret, output bit rv,
                      output int wb, output bit tr, output int te);
    ar = q.size() < 8; ai = (mhead + q.size()) % 8;
    ret = 0; rv = 0; wb = 0; tr = 0; te = 0;
    if (q.size() > 0 && q[0].r0 && q[0].r1) begin
      if (q[0].exc != 0) begin tr = 1; te = q[0].exc; end
      else begin
        if (q[0].has_wb) begin rv = 1; wb = q[0].wb; end
        ret = !q[0].has_wb || rel_ready;
      end
    end
  endtask

  task automatic compare_all();
    bit ar, ret, rv, tr; int ai, wb, te;
    calc(ar, ai, ret, rv, wb, tr, te);
    chk("R2 alloc_ready", int'(alloc_ready), int'(ar));
    chk("R2 R8 alloc_idx", int'(alloc_idx), ai);
    chk("R4 R7 R8 R9 retire", int'(retire), int'(ret));
    chk("R5 rel_valid", int'(rel_valid), int'(rv));
    if (rv) chk("R5 rel_wb_id", int'(rel_wb_id), wb);
    chk("R6 trap", int'(trap), int'(tr));
    if (tr) chk("R3 R6 trap_exc", int'(trap_exc), te);
  endtask

  task automatic model_step();
    bit ar, ret, rv, tr, full_before; int ai, wb, te, p;
    calc(ar, ai, ret, rv, wb, tr, te);
    if (tr) begin q.delete(); mhead = 0; return; end
    foreach (q[k]) begin
      bit m0 = 0, m1 = 0; int e = 0;
      for (int b = 0; b < 2; b++) begin
        if (dist_valid[b]) begin
          if (!q[k].r0 && int'(dist_tag[6*b +: 6]) == q[k].t0) begin m0 = 1; e |= int'(dist_exc[2*b +: 2]); end
          if (!q[k].r1 && int'(dist_tag[6*b +: 6]) == q[k].t1) begin m1 = 1; e |= int'(dist_exc[2*b +: 2]); end
        end
      end
      if (m0) q[k].r0 = 1;
      if (m1) q[k].r1 = 1;
      q[k].exc |= e;
      if ((br_ok || br_miss) && q[k].idx == int'(br_idx)) q[k].r0 = 1;
    end
    full_before = q.size() == 8;
    if (ret) begin void'(q.pop_front()); mhead = (mhead + 1) % 8; end
    if (br_miss) begin
      p = -1;
      foreach (q[k]) if (q[k].idx == int'(br_idx)) p = k;
      while (q.size() > p + 1) void'(q.pop_back());
    end else if (alloc_valid && !full_before) begin
      ent_t n;
      n.idx = ai; n.t0 = int'(alloc_tag0); n.t1 = int'(alloc_tag1);
      n.r0 = 0; n.r1 = 0; n.exc = 0; n.has_wb = alloc_has_wb; n.wb = int'(alloc_wb_id);
      n.br = is_br_new;
      q.push_back(n);
    end
  endtask

  task automatic gen_inputs(int cyc);
    bit quiet = (cyc % 200) < 25;
    int cand[$];
    alloc_valid  = quiet ? 1'b1 : ($urandom_range(0, 9) < 7);
    alloc_tag0   = 6'(tagc); alloc_tag1 = 6'(tagc + 1); tagc = (tagc + 2) % 64;
    alloc_has_wb = $urandom_range(0, 1);
    alloc_wb_id  = 3'($urandom_range(0, 7));
    is_br_new    = ($urandom_range(0, 9) < 3);
    rel_ready    = ($urandom_range(0, 9) < 6);
    dist_valid = '0; dist_tag = '0; dist_exc = '0;
    for (int b = 0; b < 2; b++) begin
      if (!quiet && q.size() > 0 && $urandom_range(0, 1) == 1) begin
        int k = $urandom_range(0, q.size() - 1);
        int ops[$];
        if (!q[k].r0 && !q[k].br) ops.push_back(q[k].t0);
        if (!q[k].r1) ops.push_back(q[k].t1);
        if (ops.size() > 0) begin
          dist_valid[b] = 1'b1;
          dist_tag[6*b +: 6] = 6'(ops[$urandom_range(0, ops.size() - 1)]);
          if ($urandom_range(0, 11) == 0) dist_exc[2*b +: 2] = 2'($urandom_range(1, 3));
        end
      end
    end
    br_ok = 1'b0; br_miss = 1'b0; br_idx = '0;
    foreach (q[k]) if (q[k].br && !q[k].r0) cand.push_back(q[k].idx);
    if (cand.size() > 0) begin
      if (quiet && (cyc % 200) == 22) begin
        br_miss = 1'b1; br_idx = 3'(cand[0]);
      end else if (!quiet && $urandom_range(0, 9) < 3) begin
        br_idx = 3'(cand[$urandom_range(0, cand.size() - 1)]);
        if ($urandom_range(0, 9) < 3) br_miss = 1'b1; else br_ok = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset alloc_ready", int'(alloc_ready), 1);
    chk("R1 reset alloc_idx", int'(alloc_idx), 0);
    chk("R1 reset retire", int'(retire), 0);
    chk("R1 reset rel_valid", int'(rel_valid), 0);
    chk("R1 reset trap", int'(trap), 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      compare_all();
      gen_inputs(cyc);
      model_step();
      @(negedge clk);
    end
    compare_all();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 200000; n++) @(negedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule